// File: doc/BRIEF.md
# Two's Complement Adder-Subtractor with Condition Flags

This block is a purely combinational 32-bit arithmetic unit for two's complement operands. A single select line chooses between addition and subtraction. Alongside the 32-bit result it produces three condition bits: zero, signed overflow and negative. A comparison stage downstream can use these bits to decide orderings and equality.

The datapath is structural. XOR gates controlled by the select line pass the second operand through unchanged or invert every bit of it, and the select line also drives the carry into bit 0. The result comes from a chain of one-bit full-adder cells, with each carry rippling into the next higher bit. The zero flag is a reduction tree in which no gate has more than four inputs. Overflow is computed from the operand signs as they enter the adder, so the second operand's sign is taken after the conditional inversion. The carry out of the top bit is dropped.

Top module: `addsub_flags`

## Requirements
- R1: With sub_i = 0, res_o equals (a_i + b_i) modulo 2^32 once the inputs settle, with no clock involved.
- R2: With sub_i = 1, res_o equals (a_i - b_i) modulo 2^32. This is formed as a_i + ~b_i + 1, with the +1 entering as the carry into bit 0.
- R3: The carry out of bit 31 is dropped. For example, 0xFFFFFFFF + 1 gives res_o = 0 with ovf_o = 0 and zero_o = 1.
- R4: neg_o equals res_o[31], where bit 31 is the most significant bit of every bus.
- R5: zero_o is 1 exactly when all 32 bits of res_o are 0.
- R6: ovf_o is 1 when both adder inputs (a_i and the conditionally inverted b_i) have the same sign and the sign of res_o differs from it. Examples are 0x7FFFFFFF + 1 and 0x80000000 - 1.
- R7: ovf_o is 0 whenever a_i and the conditionally inverted b_i differ in sign. Examples are A - A and 0x80000000 - 0x80000000.
- R8: Overflow uses bit 31 of b_i after inversion, not raw b_i[31]. So 0 - 0x80000000 gives res_o = 0x80000000 with ovf_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand, two's complement |
| b_i | input | 32 | Second operand, two's complement |
| sub_i | input | 1 | 0 selects addition, 1 selects subtraction |
| res_o | output | 32 | Result |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Signed overflow |
| neg_o | output | 1 | Result sign bit |

## Verification
Sign-boundary operands are tried in both modes.

- Maximum positive plus one and minimum negative minus one must raise overflow.
- The minimum value minus itself and A - A must clear overflow and raise zero. This separates overflow cases from zero-result cases.
- Zero minus the minimum value tells a correct post-inversion sign from the raw sign of B. With the raw sign, overflow would read 0 instead of 1.
- All-ones plus one shows that the dropped top carry leaves no trace in the flags.
- Random pairs in both modes compare all four outputs against a signed 64-bit reference. This exposes any single broken carry link or tree branch.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned GATE_FI = 4;

  // entries left after l reduction levels
  function automatic int unsigned node_cnt(int unsigned n, int unsigned l);
    int unsigned c;
    c = n;
    for (int unsigned k = 0; k < l; k++) c = (c + GATE_FI - 1) / GATE_FI;
    return c;
  endfunction

  function automatic int unsigned tree_levels(int unsigned n);
    int unsigned c;
    int unsigned lv;
    c  = n;
    lv = 0;
    while (c > 1) begin
      c  = (c + GATE_FI - 1) / GATE_FI;
      lv = lv + 1;
    end
    return lv;
  endfunction
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic cin_i,
  output logic sum_o,
  output logic cout_o
);
  logic p;
  assign p      = a_i ^ b_i;
  assign sum_o  = p ^ cin_i;
  assign cout_o = (a_i & b_i) | (cin_i & p);
endmodule

// File: rtl/b_invert.sv
module b_invert #(
  parameter int unsigned WIDTH = addsub_pkg::DATA_W
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic             inv_i,
  output logic [WIDTH-1:0] xb_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_xor
    assign xb_o[i] = b_i[i] ^ inv_i;
  end
endmodule

// File: rtl/ripple_adder.sv
module ripple_adder #(
  parameter int unsigned WIDTH = addsub_pkg::DATA_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o
);
  logic [WIDTH:0] c;
  assign c[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    fa_cell u_fa (
      .a_i   (a_i[i]),
      .b_i   (b_i[i]),
      .cin_i (c[i]),
      .sum_o (sum_o[i]),
      .cout_o(c[i+1])
    );
  end

  // R1 R2: chain matches a full-width sum including the dropped carry
  always_comb begin
    ripple_sum_chk: assert ({c[WIDTH], sum_o} ==
                            ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
      else $error("ripple chain mismatch");
  end
endmodule

// File: rtl/zero_tree.sv
module zero_tree #(
  parameter int unsigned WIDTH = addsub_pkg::DATA_W
) (
  input  logic [WIDTH-1:0] s_i,
  output logic             zero_o
);
  import addsub_pkg::*;
  localparam int unsigned LV = tree_levels(WIDTH);

  for (genvar l = 0; l <= LV; l++) begin : g_lvl
    localparam int unsigned C = node_cnt(WIDTH, l);
    logic [C-1:0] v;
    if (l == 0) begin : g_leaf
      assign v = s_i;
    end else begin : g_node
      localparam int unsigned PC = node_cnt(WIDTH, l - 1);
      for (genvar j = 0; j < C; j++) begin : g_gate
        localparam int unsigned LO = j * GATE_FI;
        localparam int unsigned HI = (LO + GATE_FI - 1 < PC) ? LO + GATE_FI - 1 : PC - 1;
        assign v[j] = |g_lvl[l-1].v[HI:LO];
      end
    end
  end

  assign zero_o = ~g_lvl[LV].v[0];

  // R5
  always_comb begin
    zero_flag_chk: assert (zero_o == (s_i == '0)) else $error("zero tree wrong");
  end
endmodule

// File: rtl/flag_unit.sv
module flag_unit #(
  parameter int unsigned WIDTH = addsub_pkg::DATA_W
) (
  input  logic [WIDTH-1:0] s_i,
  input  logic             a_msb_i,
  input  logic             xb_msb_i,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             neg_o
);
  logic s_msb;
  assign s_msb = s_i[WIDTH-1];
  assign neg_o = s_msb;
  assign ovf_o = (a_msb_i & xb_msb_i & ~s_msb) | (~a_msb_i & ~xb_msb_i & s_msb);

  zero_tree #(.WIDTH(WIDTH)) u_zero (
    .s_i   (s_i),
    .zero_o(zero_o)
  );

  always_comb begin
    // R7
    no_overflow_chk: assert (!(a_msb_i != xb_msb_i) || !ovf_o)
      else $error("overflow with mixed signs");
    // R6
    ovf_sign_chk: assert (!ovf_o || (neg_o != a_msb_i))
      else $error("overflow without sign flip");
  end
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int unsigned WIDTH = addsub_pkg::DATA_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             neg_o
);
  logic [WIDTH-1:0] xb;

  b_invert #(.WIDTH(WIDTH)) u_inv (
    .b_i  (b_i),
    .inv_i(sub_i),
    .xb_o (xb)
  );

  ripple_adder #(.WIDTH(WIDTH)) u_add (
    .a_i  (a_i),
    .b_i  (xb),
    .cin_i(sub_i),
    .sum_o(res_o)
  );

  flag_unit #(.WIDTH(WIDTH)) u_flags (
    .s_i     (res_o),
    .a_msb_i (a_i[WIDTH-1]),
    .xb_msb_i(xb[WIDTH-1]),
    .zero_o  (zero_o),
    .ovf_o   (ovf_o),
    .neg_o   (neg_o)
  );

  always_comb begin
    // R2
    sub_result_chk: assert (!sub_i || (res_o == a_i - b_i)) else $error("subtract wrong");
    // R1
    add_result_chk: assert (sub_i || (res_o == a_i + b_i)) else $error("add wrong");
    // R4
    neg_flag_chk: assert (neg_o == (res_o >= (WIDTH'(1) << (WIDTH - 1))))
      else $error("neg flag wrong");
  end
endmodule

// File: tb/addsub_flags_tb.sv
module addsub_flags_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int WATCHDOG = 20000;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         sub;
    logic [W-1:0] s;
    logic         z;
    logic         v;
    logic         n;
    string        sreq;
    string        vreq;
  } item_t;

  logic clk = 1'b0;
  logic [W-1:0] a, b, res;
  logic sub, zero, ovf, neg;
  item_t sbq[$];
  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit drv_done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  addsub_flags u_dut (
    .a_i(a), .b_i(b), .sub_i(sub),
    .res_o(res), .zero_o(zero), .ovf_o(ovf), .neg_o(neg)
  );

  task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference model: signed 64-bit math
  task automatic drive(logic [W-1:0] av, logic [W-1:0] bv, logic sv, string sreq);
    item_t it;
    longint ra, rb, r;
    logic xb31;
    ra = longint'($signed(av));
    rb = longint'($signed(bv));
    r  = sv ? ra - rb : ra + rb;
    it.a = av; it.b = bv; it.sub = sv;
    it.s = sv ? av - bv : av + bv;
    it.z = (it.s == '0);
    it.n = it.s[W-1];
    it.v = (r > longint'(32'h7FFF_FFFF)) || (r < -longint'(64'h8000_0000));
    it.sreq = sreq;
    xb31 = bv[W-1] ^ sv;
    if (sv && bv == 32'h8000_0000 && !av[W-1]) it.vreq = "R8";
    else if (av[W-1] != xb31) it.vreq = "R7";
    else it.vreq = "R6";
    @(posedge clk);
    a = av; b = bv; sub = sv;
    sbq.push_back(it);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      check(it.sreq, "res", res, it.s);
      check("R5", "zero", W'(zero), W'(it.z));
      check("R4", "neg", W'(neg), W'(it.n));
      check(it.vreq, "ovf", W'(ovf), W'(it.v));
    end
  end

  initial begin
    a = '0; b = '0; sub = 1'b0;
    drive(32'h0000_0000, 32'h0000_0000, 1'b0, "R1");
    drive(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, "R1");
    drive(32'h8000_0000, 32'h0000_0001, 1'b1, "R2");
    drive(32'h8000_0000, 32'h8000_0000, 1'b1, "R2");
    drive(32'h1234_5678, 32'h1234_5678, 1'b1, "R2");
    drive(32'h0000_0000, 32'h8000_0000, 1'b1, "R2");
    drive(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R3");
    drive(32'h8000_0000, 32'h8000_0000, 1'b0, "R3");
    drive(32'h0000_0005, 32'h0000_0007, 1'b1, "R2");
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R2");
    drive(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "R2");
    drive(32'h0000_0000, 32'h0000_0000, 1'b1, "R2");
    drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R1");
    for (int i = 0; i < 400; i++) begin
      logic sv;
      sv = $urandom_range(0, 1) == 1;
      drive($urandom, $urandom, sv, sv ? "R2" : "R1");
    end
    @(posedge clk);
    @(posedge clk);
    drv_done = 1'b1;
  end

  initial begin
    fork
      wait (drv_done && sbq.size() == 0);
      begin
        wait (cyc >= WATCHDOG);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule